// File: doc/BRIEF.md
# USB Endpoint Receive Handshake Controller

This block holds one receive control register per USB device endpoint and picks the handshake for each OUT or SETUP data packet that a packet engine has already decoded. For every presented transaction it takes the token type, the 4-bit token address, a packet-good flag and the DATA0/DATA1 toggle of the received data PID. One cycle later it answers with ACK, NAK, STALL or silence. When a packet is accepted as a new correct transfer, it raises a one-cycle event naming the endpoint.

Each register packs a receive toggle, a 2-bit receive state and, for endpoints other than 0, a software-programmed 4-bit endpoint address. After every correct transfer the hardware sets the endpoint to NAK. Firmware reads the data and then re-arms the endpoint through the register port. Endpoint 0 answers address 0, always reads with its top bit set and its low nibble clear, and also returns to its reset value on a USB bus reset.

Top module: `usb_rx_hs_ctrl`

## Requirements
- R1: After rst_ni is asserted, endpoint 0 reads 8'h80 and every other endpoint reads 8'h00, and no handshake or event is output.
- R2: Register layout: bit 6 is the receive toggle, bits 5:4 the receive state (00 off, 01 stall, 10 nak, 11 ready), bits 3:0 the endpoint address. Endpoint 0 always reads bit 7 = 1 and bits 3:0 = 0. Other endpoints read bit 7 = 0, and software writes set bits 6:0.
- R3: A token is routed to the lowest-numbered endpoint whose address field equals the token address, and endpoint 0 has address 0. If no endpoint matches, no handshake is given.
- R4: An endpoint in state off gives no handshake, and its register does not change.
- R5: An endpoint in state stall answers STALL, and one in state nak answers NAK. Neither changes its register.
- R6: An endpoint in state ready whose data toggle equals the expected toggle answers ACK and pulses ctr_o with ctr_ep_o set to the endpoint index. In the same update its state becomes nak and its toggle inverts.
- R7: An endpoint in state ready whose data toggle differs from the expected toggle answers ACK without ctr_o, and its register does not change.
- R8: For a SETUP token to endpoint 0 the expected toggle is 0, whatever the stored toggle.
- R9: When data_good_i is low there is no handshake and no register change.
- R10: A register write in the same cycle as a hardware update of that endpoint keeps the hardware toggle and state and takes the written address bits.
- R11: bus_rst_i returns endpoint 0 to 8'h80, leaves the other endpoints unchanged, and suppresses any handshake for a token presented in the same cycle.
- R12: hs_valid_o, hs_code_o (00 ACK, 01 NAK, 10 STALL), ctr_o and ctr_ep_o appear on the cycle after the token cycle. When no token is presented they are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rst_i | input | 1 | USB bus reset seen on the line, synchronous |
| tok_valid_i | input | 1 | One-cycle strobe: a transaction's data phase is complete |
| tok_setup_i | input | 1 | 1 for a SETUP token, 0 for OUT |
| tok_addr_i | input | 4 | Endpoint address from the token |
| data_good_i | input | 1 | Data packet received without error |
| data_pid_i | input | 1 | Toggle of the received data PID (0 = DATA0) |
| hs_valid_o | output | 1 | A handshake must be sent |
| hs_code_o | output | 2 | Handshake type: 00 ACK, 01 NAK, 10 STALL |
| ctr_o | output | 1 | One-cycle correct-transfer event |
| ctr_ep_o | output | 2 | Endpoint index of the correct transfer |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Endpoint index for register read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_idx_i, combinational |

## Verification
The hardest case to reach is a software write that lands on the same clock edge as the hardware's forced NAK for that endpoint. The two must be merged field by field. The bench reaches it by driving the register write strobe and a matching, in-toggle token on the same falling edge. It then reads the register back to see the written address next to the hardware's state and toggle. The toggle-mismatch retry and the SETUP-forces-DATA0 case need a stored toggle set opposite to the packet. The bench gets there by first writing that toggle through the register port.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 4;
  localparam int TOG_BIT = 6;
  localparam int ST_HI   = 5;
  localparam int ST_LO   = 4;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_READY = 2'b11
  } rx_st_e;
endpackage

// File: rtl/usb_rx_ep_reg.sv
module usb_rx_ep_reg
  import usb_rx_pkg::*;
#(
  parameter bit IS_EP0 = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              sw_we_i,
  input  logic [REG_W-1:0]  sw_wdata_i,
  input  logic              hw_we_i,
  input  logic              hw_tog_i,
  input  logic [1:0]        hw_st_i,
  output logic [REG_W-1:0]  reg_o,
  output logic [1:0]        st_o,
  output logic              tog_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic       tog_q;
  logic [1:0] st_q;
  logic       bus_clr;

  assign bus_clr = bus_rst_i && IS_EP0;

  // hardware update is applied last so it wins over software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      st_q  <= ST_OFF;
    end else if (bus_clr) begin
      tog_q <= 1'b0;
      st_q  <= ST_OFF;
    end else begin
      if (sw_we_i) begin
        tog_q <= sw_wdata_i[TOG_BIT];
        st_q  <= sw_wdata_i[ST_HI:ST_LO];
      end
      if (hw_we_i) begin
        tog_q <= hw_tog_i;
        st_q  <= hw_st_i;
      end
    end
  end

  generate
    if (IS_EP0) begin : g_ep0
      logic unused_wbits;
      assign unused_wbits = ^{sw_wdata_i[REG_W-1], sw_wdata_i[ADDR_W-1:0]};
      assign addr_o = '0;
      assign reg_o  = {1'b1, tog_q, st_q, {ADDR_W{1'b0}}};
    end else begin : g_epn
      logic [ADDR_W-1:0] addr_q;
      logic unused_wbit;
      assign unused_wbit = sw_wdata_i[REG_W-1];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      addr_q <= '0;
        else if (sw_we_i) addr_q <= sw_wdata_i[ADDR_W-1:0];
      end
      assign addr_o = addr_q;
      assign reg_o  = {1'b0, tog_q, st_q, addr_q};
    end
  endgenerate

  assign st_o  = st_q;
  assign tog_o = tog_q;
endmodule

// File: rtl/usb_rx_decide.sv
module usb_rx_decide
  import usb_rx_pkg::*;
#(
  parameter int NUM_EP = 3,
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                           tok_valid_i,
  input  logic                           tok_setup_i,
  input  logic [ADDR_W-1:0]              tok_addr_i,
  input  logic                           data_good_i,
  input  logic                           data_pid_i,
  input  logic [NUM_EP-1:0][1:0]         st_i,
  input  logic [NUM_EP-1:0]              tog_i,
  input  logic [NUM_EP-1:0][ADDR_W-1:0]  addr_i,
  output logic                           hs_en_o,
  output logic [1:0]                     hs_code_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic                           upd_o,
  output logic                           new_tog_o,
  output logic                           ctr_o
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [1:0]       sel_st;
  logic             exp_tog;

  // lowest index wins: scan downward, last match sticks
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      if (addr_i[i] == tok_addr_i) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign sel_st  = st_i[idx];
  assign exp_tog = (tok_setup_i && (idx == '0)) ? 1'b0 : tog_i[idx];

  always_comb begin
    hs_en_o   = 1'b0;
    hs_code_o = HS_ACK;
    upd_o     = 1'b0;
    new_tog_o = 1'b0;
    ctr_o     = 1'b0;
    if (tok_valid_i && data_good_i && hit) begin
      unique case (sel_st)
        ST_STALL: begin
          hs_en_o   = 1'b1;
          hs_code_o = HS_STALL;
        end
        ST_NAK: begin
          hs_en_o   = 1'b1;
          hs_code_o = HS_NAK;
        end
        ST_READY: begin
          hs_en_o   = 1'b1;
          hs_code_o = HS_ACK;
          if (data_pid_i == exp_tog) begin
            upd_o     = 1'b1;
            new_tog_o = ~exp_tog;
            ctr_o     = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign idx_o = idx;
endmodule

// File: rtl/usb_rx_hs_ctrl.sv
module usb_rx_hs_ctrl
  import usb_rx_pkg::*;
#(
  parameter int NUM_EP = 3,
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              tok_valid_i,
  input  logic              tok_setup_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic              data_good_i,
  input  logic              data_pid_i,
  output logic              hs_valid_o,
  output logic [1:0]        hs_code_o,
  output logic              ctr_o,
  output logic [IDX_W-1:0]  ctr_ep_o,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  logic [NUM_EP-1:0][1:0]        st;
  logic [NUM_EP-1:0]             tog;
  logic [NUM_EP-1:0][ADDR_W-1:0] addr;
  logic [NUM_EP*REG_W-1:0]       regs_flat;

  logic             tok_gated;
  logic             hs_en, upd, new_tog, ctr;
  logic [1:0]       hs_code;
  logic [IDX_W-1:0] idx;

  assign tok_gated = tok_valid_i && !bus_rst_i;

  usb_rx_decide #(.NUM_EP(NUM_EP)) u_decide (
    .tok_valid_i (tok_gated),
    .tok_setup_i (tok_setup_i),
    .tok_addr_i  (tok_addr_i),
    .data_good_i (data_good_i),
    .data_pid_i  (data_pid_i),
    .st_i        (st),
    .tog_i       (tog),
    .addr_i      (addr),
    .hs_en_o     (hs_en),
    .hs_code_o   (hs_code),
    .idx_o       (idx),
    .upd_o       (upd),
    .new_tog_o   (new_tog),
    .ctr_o       (ctr)
  );

  generate
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      logic [REG_W-1:0] reg_v;
      usb_rx_ep_reg #(.IS_EP0(g == 0)) u_reg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bus_rst_i  (bus_rst_i),
        .sw_we_i    (reg_we_i && (reg_idx_i == IDX_W'(g))),
        .sw_wdata_i (reg_wdata_i),
        .hw_we_i    (upd && (idx == IDX_W'(g))),
        .hw_tog_i   (new_tog),
        .hw_st_i    (ST_NAK),
        .reg_o      (reg_v),
        .st_o       (st[g]),
        .tog_o      (tog[g]),
        .addr_o     (addr[g])
      );
      assign regs_flat[g*REG_W +: REG_W] = reg_v;
    end
  endgenerate

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (reg_idx_i == IDX_W'(i)) reg_rdata_o = regs_flat[i*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_valid_o <= 1'b0;
      hs_code_o  <= HS_ACK;
      ctr_o      <= 1'b0;
      ctr_ep_o   <= '0;
    end else begin
      hs_valid_o <= hs_en;
      hs_code_o  <= hs_code;
      ctr_o      <= ctr;
      ctr_ep_o   <= ctr ? idx : '0;
    end
  end
endmodule

// File: rtl/usb_rx_hs_ctrl_chk.sv
module usb_rx_hs_ctrl_chk #(
  parameter int NUM_EP = 3,
  parameter int IDX_W  = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_rst_i,
  input logic                tok_valid_i,
  input logic                data_good_i,
  input logic                hs_valid_o,
  input logic [1:0]          hs_code_o,
  input logic                ctr_o,
  input logic [IDX_W-1:0]    ctr_ep_o,
  input logic [NUM_EP*8-1:0] regs_i
);
  a_r9_bad_data_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && !data_good_i |=> !hs_valid_o && !ctr_o);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_valid_i |=> !hs_valid_o && !ctr_o);

  a_r6_ctr_is_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_o |-> hs_valid_o && hs_code_o == 2'b00);

  a_r6_ctr_leaves_nak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_o |-> regs_i[ctr_ep_o*8 + 4 +: 2] == 2'b10);

  a_r11_bus_rst_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !hs_valid_o && !ctr_o);

  a_r2_ep0_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_i[7] && regs_i[3:0] == 4'h0);

  a_r12_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> hs_code_o != 2'b11);
endmodule

bind usb_rx_hs_ctrl usb_rx_hs_ctrl_chk #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_rst_i   (bus_rst_i),
  .tok_valid_i (tok_valid_i),
  .data_good_i (data_good_i),
  .hs_valid_o  (hs_valid_o),
  .hs_code_o   (hs_code_o),
  .ctr_o       (ctr_o),
  .ctr_ep_o    (ctr_ep_o),
  .regs_i      (regs_flat)
);

// File: tb/usb_rx_hs_ctrl_tb_top.sv
module usb_rx_hs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP     = 3;

  typedef struct packed {
    logic       setup;
    logic [3:0] addr;
    logic       good;
    logic       pid;
    logic [1:0] rd_idx;
    logic       exp_v;
    logic [1:0] exp_code;
    logic       exp_ctr;
    logic [1:0] exp_ep;
    logic [7:0] exp_reg;
  } vec_t;

  // state before the table: ep0=B0 (ready), ep1=33 (ready,addr3), ep2=15 (stall,addr5)
  localparam vec_t VECS [7] = '{
    '{1'b0, 4'd3, 1'b1, 1'b0, 2'd1, 1'b1, 2'b00, 1'b1, 2'd1, 8'h63}, // R6
    '{1'b0, 4'd3, 1'b1, 1'b1, 2'd1, 1'b1, 2'b01, 1'b0, 2'd0, 8'h63}, // R5 nak
    '{1'b0, 4'd5, 1'b1, 1'b0, 2'd2, 1'b1, 2'b10, 1'b0, 2'd0, 8'h15}, // R5 stall
    '{1'b0, 4'd7, 1'b1, 1'b0, 2'd1, 1'b0, 2'b00, 1'b0, 2'd0, 8'h63}, // R3 miss
    '{1'b0, 4'd3, 1'b0, 1'b1, 2'd1, 1'b0, 2'b00, 1'b0, 2'd0, 8'h63}, // R9
    '{1'b1, 4'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'b00, 1'b1, 2'd0, 8'hE0}, // R6 ep0
    '{1'b0, 4'd0, 1'b1, 1'b1, 2'd0, 1'b1, 2'b01, 1'b0, 2'd0, 8'hE0}  // R5 ep0
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_rst_i = 1'b0;
  logic       tok_valid_i = 1'b0;
  logic       tok_setup_i = 1'b0;
  logic [3:0] tok_addr_i = '0;
  logic       data_good_i = 1'b0;
  logic       data_pid_i = 1'b0;
  logic       hs_valid_o;
  logic [1:0] hs_code_o;
  logic       ctr_o;
  logic [1:0] ctr_ep_o;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_idx_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usb_rx_hs_ctrl #(.NUM_EP(NUM_EP)) dut_i (
    .clk_i, .rst_ni, .bus_rst_i, .tok_valid_i, .tok_setup_i, .tok_addr_i,
    .data_good_i, .data_pid_i, .hs_valid_o, .hs_code_o, .ctr_o, .ctr_ep_o,
    .reg_we_i, .reg_idx_i, .reg_wdata_i, .reg_rdata_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] idx, input logic [7:0] exp);
    reg_idx_i = idx;
    #1;
    check(req, {24'h0, reg_rdata_o}, {24'h0, exp});
  endtask

  // drive one token for one cycle; on return the outputs of that edge are visible
  task automatic tok(input logic setup, input logic [3:0] addr, input logic good, input logic pid);
    @(negedge clk_i);
    tok_valid_i = 1'b1; tok_setup_i = setup; tok_addr_i = addr;
    data_good_i = good; data_pid_i = pid;
    @(negedge clk_i);
    tok_valid_i = 1'b0;
  endtask

  task automatic hs_chk(input string req, input logic v, input logic [1:0] code,
                        input logic c, input logic [1:0] ep);
    check({req, " hs_valid"}, {31'h0, hs_valid_o}, {31'h0, v});
    if (v) check({req, " hs_code"}, {30'h0, hs_code_o}, {30'h0, code});
    check({req, " ctr"}, {31'h0, ctr_o}, {31'h0, c});
    if (c) check({req, " ctr_ep"}, {30'h0, ctr_ep_o}, {30'h0, ep});
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    rd_chk("R1 ep0", 2'd0, 8'h80);
    rd_chk("R1 ep1", 2'd1, 8'h00);
    rd_chk("R1 ep2", 2'd2, 8'h00);
    check("R1 hs_valid", {31'h0, hs_valid_o}, 32'h0);
    rst_ni = 1'b1;

    // R2 fixed and reserved bits
    wr(2'd0, 8'hFF); rd_chk("R2 ep0 write FF", 2'd0, 8'hF0);
    wr(2'd1, 8'hFF); rd_chk("R2 ep1 write FF", 2'd1, 8'h7F);

    // table setup
    wr(2'd0, 8'h30); wr(2'd1, 8'h33); wr(2'd2, 8'h15);
    rd_chk("R2 ep0 setup", 2'd0, 8'hB0);
    for (int i = 0; i < 7; i++) begin
      tok(VECS[i].setup, VECS[i].addr, VECS[i].good, VECS[i].pid);
      hs_chk($sformatf("R12 vec%0d", i), VECS[i].exp_v, VECS[i].exp_code,
             VECS[i].exp_ctr, VECS[i].exp_ep);
      rd_chk($sformatf("R6/R5 vec%0d reg", i), VECS[i].rd_idx, VECS[i].exp_reg);
    end
    @(negedge clk_i);
    hs_chk("R12 idle", 1'b0, 2'b00, 1'b0, 2'd0);

    // R7 toggle mismatch on ep1
    wr(2'd1, 8'h73);
    tok(1'b0, 4'd3, 1'b1, 1'b0);
    hs_chk("R7", 1'b1, 2'b00, 1'b0, 2'd0);
    rd_chk("R7 reg", 2'd1, 8'h73);

    // R8 SETUP expects DATA0 though stored toggle is 1
    wr(2'd0, 8'h70);
    tok(1'b0, 4'd0, 1'b1, 1'b0);
    hs_chk("R7 ep0 OUT mismatch", 1'b1, 2'b00, 1'b0, 2'd0);
    rd_chk("R7 ep0 reg", 2'd0, 8'hF0);
    tok(1'b1, 4'd0, 1'b1, 1'b0);
    hs_chk("R8", 1'b1, 2'b00, 1'b1, 2'd0);
    rd_chk("R8 reg", 2'd0, 8'hE0);

    // R4 disabled endpoint
    wr(2'd1, 8'h03);
    tok(1'b0, 4'd3, 1'b1, 1'b0);
    hs_chk("R4", 1'b0, 2'b00, 1'b0, 2'd0);
    rd_chk("R4 reg", 2'd1, 8'h03);

    // R10 software write collides with hardware NAK
    wr(2'd1, 8'h33);
    @(negedge clk_i);
    tok_valid_i = 1'b1; tok_setup_i = 1'b0; tok_addr_i = 4'd3;
    data_good_i = 1'b1; data_pid_i = 1'b0;
    reg_we_i = 1'b1; reg_idx_i = 2'd1; reg_wdata_i = 8'h35;
    @(negedge clk_i);
    tok_valid_i = 1'b0; reg_we_i = 1'b0;
    hs_chk("R10", 1'b1, 2'b00, 1'b1, 2'd1);
    rd_chk("R10 reg", 2'd1, 8'h65);

    // R3 overlapping addresses: lowest index wins
    wr(2'd1, 8'h36); wr(2'd2, 8'h16);
    tok(1'b0, 4'd6, 1'b1, 1'b0);
    hs_chk("R3 overlap", 1'b1, 2'b00, 1'b1, 2'd1);
    rd_chk("R3 ep2 untouched", 2'd2, 8'h16);

    // R11 bus reset
    wr(2'd0, 8'h30); wr(2'd1, 8'h33);
    @(negedge clk_i);
    bus_rst_i = 1'b1; tok_valid_i = 1'b1; tok_addr_i = 4'd3;
    data_good_i = 1'b1; data_pid_i = 1'b0;
    @(negedge clk_i);
    bus_rst_i = 1'b0; tok_valid_i = 1'b0;
    hs_chk("R11", 1'b0, 2'b00, 1'b0, 2'd0);
    rd_chk("R11 ep0", 2'd0, 8'h80);
    rd_chk("R11 ep1", 2'd1, 8'h33);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule